// File: doc/BRIEF.md
# Dynamic Phase-Shift Port Responder

This block stands in for the PLL end of a dynamic phase-shift handshake. A controller that issues single phase steps can be run against it, and the block also checks that the controller follows the protocol. It keeps one phase index per selectable output counter. Each accepted request moves the selected index up or down by one step. The index wraps modulo a configurable number of steps per output period. Clock generation and the VCO are not modelled.

Everything runs on one fast clock. The scan clock arrives as a plain input, and the block finds its rising and falling edges by comparing each sample with the previous one. The step request is taken at a falling scan edge. Direction and counter select are taken at the second rising scan edge after that. On that same edge the done output drops. It stays low for a programmable number of fast-clock cycles, and it rises on the cycle in which the step is applied. Two kinds of misuse set a sticky violation flag: a request that is dropped too early, and a fresh request made while done is low.

Top module: `dps_responder`

## Requirements
- R1: After reset, done is 1, viol is 0 and every phase index is 0.
- R2: A request is taken only at a falling scan-clock edge where step_req is 1 and was seen as 0 at the previous falling edge. Done stays 1 through the first rising scan edge that follows.
- R3: Done goes to 0 on the clock that detects the second rising scan edge after the request was taken.
- R4: Done stays 0 for exactly busy_len fast-clock cycles. A busy_len of 0 is treated as 1.
- R5: dir_up and cnt_sel are captured at the second rising scan edge, and later changes to them have no effect on the step. dir_up=1 adds one and dir_up=0 subtracts one. Counter i is held in phase_all[i*PH_W +: PH_W].
- R6: A step wraps: NSTEPS-1 plus one gives 0, and 0 minus one gives NSTEPS-1.
- R7: A select value of NCNT or more completes the handshake and changes no phase index.
- R8: A request still held after done has returned to 1 does not produce a second step. A new step needs step_req to be seen low at a falling edge first.
- R9: If step_req is 0 at any scan edge between the taking of a request and its capture edge, viol is set, no step is made and done stays 1.
- R10: A fresh request seen at a falling scan edge while done is 0 sets viol and is not acted on.
- R11: Once set, viol stays 1 until reset, even while later steps complete normally.
- R12: Phase indices change only on the clock on which done returns to 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Fast clock that samples all inputs |
| rst_n | input | 1 | Active-low asynchronous reset |
| scan_clk | input | 1 | Scan clock, sampled as data |
| step_req | input | 1 | Phase-step request from the controller |
| dir_up | input | 1 | Step direction: 1 = up, 0 = down |
| cnt_sel | input | SEL_W | Index of the counter to step |
| busy_len | input | BUSY_W | Done-low time in fast-clock cycles |
| done | output | 1 | Handshake done, low while a step is in progress |
| viol | output | 1 | Sticky protocol-violation flag |
| phase_all | output | NCNT*PH_W | Phase index of every counter, counter 0 in the low bits |

## Verification
The sweep covers every done-low length, every select value including the unused ones, and long runs in both directions so that each counter wraps past both ends. A design that latched direction or select late would take the altered values the bench drives while done is low. A design with an off-by-one timer would give a wrong low count. A design that dropped done one scan edge early or late fails the done check made after each rising edge. Separate scenarios hold the request through recovery, drop it too early, and re-raise it while done is low. These catch a design that double-steps, one that misses either violation, and one that lets the flag clear.

// File: rtl/dps_pkg.sv
package dps_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_ARMED = 2'd1,
        ST_BUSY  = 2'd2
    } resp_state_e;

endpackage

// File: rtl/dps_edge.sv
module dps_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic sig,
    output logic rise,
    output logic fall
);
    logic prev_d, prev_q;

    always_comb begin
        prev_d = sig;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= 1'b0;
        else        prev_q <= prev_d;
    end

    assign rise = sig & ~prev_q;
    assign fall = ~sig & prev_q;
endmodule

// File: rtl/dps_busy_timer.sv
module dps_busy_timer #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] len,
    output logic         expire
);
    localparam logic [W-1:0] ONE = W'(1);

    logic [W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load)
            cnt_d = (len == '0) ? ONE : len;
        else if (cnt_q != '0)
            cnt_d = cnt_q - ONE;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign expire = (cnt_q == ONE);
endmodule

// File: rtl/dps_phase_bank.sv
module dps_phase_bank #(
    parameter int NCNT   = 5,
    parameter int NSTEPS = 6,
    parameter int PH_W   = 3,
    parameter int SEL_W  = 3
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 apply,
    input  logic                 up,
    input  logic [SEL_W-1:0]     sel,
    output logic [NCNT*PH_W-1:0] phase_all
);
    localparam logic [PH_W-1:0] TOP = PH_W'(NSTEPS - 1);
    localparam logic [PH_W-1:0] ONE = PH_W'(1);

    for (genvar i = 0; i < NCNT; i++) begin : g_cnt
        logic [PH_W-1:0] ph_d, ph_q;

        always_comb begin
            ph_d = ph_q;
            if (apply && (sel == SEL_W'(i))) begin
                if (up) ph_d = (ph_q == TOP) ? '0 : ph_q + ONE;
                else    ph_d = (ph_q == '0) ? TOP : ph_q - ONE;
            end
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) ph_q <= '0;
            else        ph_q <= ph_d;
        end

        assign phase_all[i*PH_W +: PH_W] = ph_q;
    end
endmodule

// File: rtl/dps_responder.sv
module dps_responder
    import dps_pkg::*;
#(
    parameter int NCNT   = 5,
    parameter int NSTEPS = 6,
    parameter int BUSY_W = 4,
    parameter int SEL_W  = (NCNT > 1) ? $clog2(NCNT) : 1,
    parameter int PH_W   = (NSTEPS > 1) ? $clog2(NSTEPS) : 1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 scan_clk,
    input  logic                 step_req,
    input  logic                 dir_up,
    input  logic [SEL_W-1:0]     cnt_sel,
    input  logic [BUSY_W-1:0]    busy_len,
    output logic                 done,
    output logic                 viol,
    output logic [NCNT*PH_W-1:0] phase_all
);
    typedef struct packed {
        resp_state_e      st;
        logic             req_lat;
        logic             rise1;
        logic             up;
        logic [SEL_W-1:0] sel;
        logic             done;
        logic             viol;
    } ctl_t;

    ctl_t d, q;
    logic s_rise, s_fall;
    logic tmr_load, tmr_expire, apply;

    dps_edge i_edge (
        .clk  (clk),
        .rst_n(rst_n),
        .sig  (scan_clk),
        .rise (s_rise),
        .fall (s_fall)
    );

    dps_busy_timer #(.W(BUSY_W)) i_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (tmr_load),
        .len   (busy_len),
        .expire(tmr_expire)
    );

    dps_phase_bank #(
        .NCNT(NCNT), .NSTEPS(NSTEPS), .PH_W(PH_W), .SEL_W(SEL_W)
    ) i_bank (
        .clk      (clk),
        .rst_n    (rst_n),
        .apply    (apply),
        .up       (q.up),
        .sel      (q.sel),
        .phase_all(phase_all)
    );

    always_comb begin
        d        = q;
        tmr_load = 1'b0;
        apply    = 1'b0;
        // the request level seen at each falling edge separates fresh from held requests
        if (s_fall) d.req_lat = step_req;
        unique case (q.st)
            ST_IDLE: begin
                if (s_fall && step_req && !q.req_lat) begin
                    d.st    = ST_ARMED;
                    d.rise1 = 1'b0;
                end
            end
            ST_ARMED: begin
                if ((s_rise || s_fall) && !step_req) begin
                    d.viol = 1'b1;
                    d.st   = ST_IDLE;
                end else if (s_rise) begin
                    if (q.rise1) begin
                        d.up     = dir_up;
                        d.sel    = cnt_sel;
                        d.done   = 1'b0;
                        tmr_load = 1'b1;
                        d.st     = ST_BUSY;
                    end else begin
                        d.rise1 = 1'b1;
                    end
                end
            end
            ST_BUSY: begin
                if (s_fall && step_req && !q.req_lat) d.viol = 1'b1;
                if (tmr_expire) begin
                    apply  = 1'b1;
                    d.done = 1'b1;
                    d.st   = ST_IDLE;
                end
            end
            default: d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q         <= '0;
            q.st      <= ST_IDLE;
            q.done    <= 1'b1;
        end else begin
            q <= d;
        end
    end

    assign done = q.done;
    assign viol = q.viol;
endmodule

module dps_responder_chk #(
    parameter int PW = 15
) (
    input logic          clk,
    input logic          rst_n,
    input logic          scan_clk,
    input logic          step_req,
    input logic          done,
    input logic          viol,
    input logic [PW-1:0] phase_all
);
    // R3
    done_fall_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(done) |-> ($past(scan_clk) && !$past(scan_clk, 2)));

    // R9
    done_fall_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(done) |-> $past(step_req));

    // R12
    phase_on_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(phase_all) |-> $rose(done));

    // R11
    viol_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(viol) |-> viol);
endmodule

bind dps_responder dps_responder_chk #(.PW(NCNT*PH_W)) i_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .scan_clk (scan_clk),
    .step_req (step_req),
    .done     (done),
    .viol     (viol),
    .phase_all(phase_all)
);

// File: tb/test_dps_responder.sv
`timescale 1ns/1ps
module test_dps_responder;
    localparam int NCNT = 5, NSTEPS = 6, BUSY_W = 4, SEL_W = 3, PH_W = 3;

    logic clk = 1'b0, rst_n = 1'b0;
    logic step_req = 1'b0, dir_up = 1'b0;
    logic [SEL_W-1:0] cnt_sel = '0;
    logic [BUSY_W-1:0] busy_len = '0;
    logic done, viol;
    logic [NCNT*PH_W-1:0] phase_all;
    logic [2:0] sc_cnt = '0;
    logic scan_clk;

    int n_vec = 0, n_bad = 0;
    int exp_ph [NCNT];

    always #2 clk = ~clk;
    always @(negedge clk) sc_cnt <= sc_cnt + 3'd1;
    assign scan_clk = sc_cnt[2];

    dps_responder #(.NCNT(NCNT), .NSTEPS(NSTEPS), .BUSY_W(BUSY_W)) i_dps_responder (
        .clk(clk), .rst_n(rst_n), .scan_clk(scan_clk), .step_req(step_req),
        .dir_up(dir_up), .cnt_sel(cnt_sel), .busy_len(busy_len),
        .done(done), .viol(viol), .phase_all(phase_all)
    );

    task automatic chk(string rq, int act, int exp);
        n_vec++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", rq, act, exp);
        end
    endtask

    task automatic chk_phases(string rq);
        for (int i = 0; i < NCNT; i++)
            chk(rq, int'(phase_all[i*PH_W +: PH_W]), exp_ph[i]);
    endtask

    task automatic do_reset();
        rst_n = 1'b0; step_req = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        for (int i = 0; i < NCNT; i++) exp_ph[i] = 0;
        repeat (10) @(negedge clk);
    endtask

    task automatic scan_wait(int n);
        repeat (n) @(negedge scan_clk);
        @(negedge clk);
    endtask

    // one complete handshake; hold keeps the request high after done falls
    task automatic do_step(bit up, int sel, int blen, bit hold);
        int n = 0;
        int eff;
        bit first_low = 1'b0;
        string tag = "R5";
        eff = (blen == 0) ? 1 : blen;
        busy_len = BUSY_W'(blen);
        @(posedge scan_clk); @(negedge clk);
        step_req = 1'b1; dir_up = up; cnt_sel = SEL_W'(sel);
        @(posedge scan_clk); @(negedge clk); @(negedge clk);
        chk("R2 done high after first rise", int'(done), 1);
        @(posedge scan_clk);
        for (int g = 0; g < 100; g++) begin
            @(negedge clk);
            if (done) break;
            n++;
            if (n == 1) begin
                first_low = 1'b1;
                if (!hold) step_req = 1'b0;
                dir_up  = ~up;
                cnt_sel = SEL_W'(sel + 3);
            end
        end
        chk("R3 done low at second rise", int'(first_low), 1);
        chk("R4 done low length", n, eff);
        if (sel < NCNT) begin
            if (up  && exp_ph[sel] == NSTEPS - 1) tag = "R6";
            if (!up && exp_ph[sel] == 0)          tag = "R6";
            exp_ph[sel] = up ? (exp_ph[sel] + 1) % NSTEPS : (exp_ph[sel] + NSTEPS - 1) % NSTEPS;
        end else begin
            tag = "R7";
        end
        chk_phases(tag);
        scan_wait(1);
    endtask

    initial begin
        #(200000 * 4);
        n_bad++;
        $display("FAIL watchdog: actual hang expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        int lows;
        do_reset();
        // R1
        chk("R1 done", int'(done), 1);
        chk("R1 viol", int'(viol), 0);
        chk_phases("R1");

        // sweep: R4 every length, R5/R7 every select, R6 wraps both ways
        for (int b = 0; b < (1 << BUSY_W); b++)
            for (int s = 0; s < (1 << SEL_W); s++)
                for (int k = 0; k < 2; k++)
                    do_step(b < 8, s, b, 1'b0);
        chk("R9 no viol on clean sweep", int'(viol), 0);

        // R8: held request gives one step only
        do_step(1'b1, 1, 3, 1'b1);
        scan_wait(3);
        chk_phases("R8 held request");
        chk("R8 done stays high", int'(done), 1);
        step_req = 1'b0;
        scan_wait(2);
        chk_phases("R8 after release");
        do_step(1'b1, 1, 3, 1'b0);
        chk("R8 viol clear", int'(viol), 0);

        // R9: request dropped before the first rise
        do_reset();
        @(posedge scan_clk); @(negedge clk);
        step_req = 1'b1; dir_up = 1'b1; cnt_sel = 3'd0;
        @(negedge scan_clk); @(negedge clk); @(negedge clk);
        step_req = 1'b0;
        lows = 0;
        repeat (32) begin @(negedge clk); if (!done) lows++; end
        chk("R9 done never low", lows, 0);
        chk("R9 viol set", int'(viol), 1);
        chk_phases("R9 no step");
        // R11: flag persists through a good step
        do_step(1'b1, 0, 2, 1'b0);
        scan_wait(3);
        chk("R11 viol sticky", int'(viol), 1);

        // R10: fresh request while done is low
        do_reset();
        busy_len = 4'd15;
        @(posedge scan_clk); @(negedge clk);
        step_req = 1'b1; dir_up = 1'b1; cnt_sel = 3'd2;
        @(posedge scan_clk); @(posedge scan_clk);
        @(negedge clk); @(negedge clk);
        step_req = 1'b0;
        @(negedge scan_clk); @(negedge clk); @(negedge clk);
        chk("R10 done low before re-request", int'(done), 0);
        step_req = 1'b1;
        for (int g = 0; g < 100 && !done; g++) @(negedge clk);
        exp_ph[2] = 1;
        chk("R10 viol set", int'(viol), 1);
        scan_wait(4);
        chk_phases("R10 early request ignored");
        step_req = 1'b0;
        scan_wait(2);
        chk("R11 viol still set", int'(viol), 1);

        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule